// File: doc/BRIEF.md
# GPIO Interrupt Source Selector

This block turns a wide bus of general-purpose I/O interrupt lines into thirty-two interrupt requests for a parent interrupt controller. Each request channel is mapped at run time to any one of the 128 input lines. It applies its own sense to that line: rising edge, falling edge, high level or low level. The result is held in a per-channel status bit, and that bit drives the channel's request output as an active-high level.

Software sets up the block through a simple 32-bit register bus. Each channel has a select byte, made of an enable bit and a source index, plus a 2-bit sense field. Status bits can be read back, and in the edge modes they are acknowledged by writing zero. The input lines are treated as asynchronous. They pass through a synchronizer of parameterised depth before any detection takes place.

The register bus is a control path with plain strobes and no back-pressure. A write is taken on the clock edge where `reg_wr` is high. A read strobe `reg_rd` returns its data on `reg_rdata` at the next edge, and that value is held until the next read.

Top module: `gpio_irq_selector`

## Requirements
- R1: After reset every select byte, every sense field and every status bit is zero, `irq_out` is all low, and every register reads back as zero.
- R2: Registers are word addressed. Status is at 0x20, bit n for channel n. Sense fields are at 0x24 for channels 0–15 and at 0x28 for channels 16–31, with channel n at bits 2·(n mod 16)+1:2·(n mod 16). Channel n's select byte is byte (n mod 4), bits 8·(n mod 4)+7:8·(n mod 4), of the word at 0x30 + 4·(n div 4). Read data appears one cycle after the read strobe, and an unmapped address reads as zero.
- R3: In a select byte, bit 7 enables the channel and bits 6:0 choose which `gpio_irq_in` line it watches. Activity on any other line has no effect on that channel.
- R4: A channel whose enable bit is 0 never sets its status bit, so a disabled channel in a level mode keeps its request low. Writing the whole byte to zero disables the channel.
- R5: With sense code 0, a 0-to-1 transition of the selected line sets the status bit.
- R6: With sense code 1, a 1-to-0 transition of the selected line sets the status bit.
- R7: With sense code 2 the status equals the selected line while the channel is enabled. With code 3 it equals the inverted line.
- R8: In the edge codes (0 and 1) a set status bit stays set until software writes 0 to it at 0x20. Writing 1 leaves a bit unchanged. If an edge is detected in the same cycle as a clear write, the set wins.
- R9: A write that changes a channel's select byte, including enabling it, never produces an edge by itself. The line's level at that moment is taken as the new starting history.
- R10: `irq_out[n]` is an active-high level that equals status bit n.
- R11: With the default two synchronizer stages, a change of the selected line is seen on `irq_out` at the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| gpio_irq_in | input | 128 | Asynchronous GPIO interrupt lines |
| irq_out | output | 32 | Per-channel active-high requests to the parent |

## Verification
The hardest case to reach from the ports is a new edge arriving in exactly the same cycle as software's clear write for that channel. The bench gets there by raising the selected line at a known falling clock edge and counting the two synchronizer stages. It then places the clear write so that it is captured on the very edge where the status would be set, and checks that the request survives. A second hard case is a spurious edge created when a channel's history changes under it. This is provoked by enabling a channel, and by re-pointing its index, while the newly selected line is already high in rising-edge mode.

// File: rtl/gis_pkg.sv
package gis_pkg;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  // Word indices (byte address >> 2) of the register groups.
  localparam int STAT_WORD  = 8;   // 0x20
  localparam int SENSE_WORD = 9;   // 0x24, 0x28
  localparam int SEL_WORD   = 12;  // 0x30 .. 0x4C

  localparam int SEL_EN_BIT = 7;
  localparam int CH_PER_SEL = 4;
  localparam int CH_PER_SNS = 16;

endpackage

// File: rtl/gis_sync.sv
module gis_sync #(
  parameter int WIDTH  = 128,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else begin
          stage_q[0] <= async_i;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end
      assign sync_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/gis_regs.sv
module gis_regs
  import gis_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NUM_CH-1:0]       status_i,
  output logic [NUM_CH-1:0][7:0]  sel_o,
  output logic [NUM_CH-1:0][1:0]  sense_o,
  output logic [NUM_CH-1:0]       clr_o
);

  localparam int SEL_REGS = NUM_CH / CH_PER_SEL;
  localparam int SNS_REGS = NUM_CH / CH_PER_SNS;
  localparam int WORD_W   = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [31:0]       rd_word;
  logic              mapped;

  assign word = reg_addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o   <= '0;
      sense_o <= '0;
    end else if (reg_wr) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (int'(word) == SEL_WORD + ch / CH_PER_SEL)
          sel_o[ch] <= reg_wdata[8*(ch%CH_PER_SEL) +: 8];
        if (int'(word) == SENSE_WORD + ch / CH_PER_SNS)
          sense_o[ch] <= reg_wdata[2*(ch%CH_PER_SNS) +: 2];
      end
    end
  end

  // Write-zero-to-clear acknowledge, one strobe per channel.
  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++)
      clr_o[ch] = reg_wr && (int'(word) == STAT_WORD) && !reg_wdata[ch];
  end

  always_comb begin
    rd_word = '0;
    mapped  = 1'b0;
    if (int'(word) == STAT_WORD) begin
      mapped = 1'b1;
      rd_word[NUM_CH-1:0] = status_i;
    end
    for (int r = 0; r < SNS_REGS; r++) begin
      if (int'(word) == SENSE_WORD + r) begin
        mapped = 1'b1;
        for (int k = 0; k < CH_PER_SNS; k++)
          rd_word[2*k +: 2] = sense_o[r*CH_PER_SNS + k];
      end
    end
    for (int r = 0; r < SEL_REGS; r++) begin
      if (int'(word) == SEL_WORD + r) begin
        mapped = 1'b1;
        for (int k = 0; k < CH_PER_SEL; k++)
          rd_word[8*k +: 8] = sel_o[r*CH_PER_SEL + k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

  // R2: an unmapped read returns zero on the following cycle.
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped) |=> (reg_rdata == 32'd0));

endmodule

// File: rtl/gis_channel.sv
module gis_channel
  import gis_pkg::*;
#(
  parameter int SRC_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<SRC_W)-1:0] src_bus,
  input  logic [7:0]            sel_i,
  input  logic [1:0]            sense_i,
  input  logic                  clr_i,
  output logic                  status_o
);

  logic [7:0]       sel_last_q;
  logic             prev_q;
  logic             status_q;
  logic             status_d;
  logic             en;
  logic [SRC_W-1:0] idx;
  logic             cur;
  logic             armed;
  logic             rise;
  logic             fall;
  logic             is_edge;
  sense_e           mode;

  assign en      = sel_i[SEL_EN_BIT];
  assign idx     = sel_i[SRC_W-1:0];
  assign cur     = src_bus[idx];
  assign mode    = sense_e'(sense_i);
  assign is_edge = (mode == SENSE_RISE) || (mode == SENSE_FALL);

  // History only counts once the select byte has been stable for a cycle.
  assign armed = en && (sel_i == sel_last_q);
  assign rise  = armed && !prev_q &&  cur;
  assign fall  = armed &&  prev_q && !cur;

  always_comb begin
    unique case (mode)
      SENSE_RISE: status_d = rise || (status_q && !clr_i);
      SENSE_FALL: status_d = fall || (status_q && !clr_i);
      SENSE_HIGH: status_d = en &&  cur;
      SENSE_LOW:  status_d = en && !cur;
      default:    status_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_last_q <= '0;
      prev_q     <= 1'b0;
      status_q   <= 1'b0;
    end else begin
      sel_last_q <= sel_i;
      prev_q     <= cur;
      status_q   <= status_d;
    end
  end

  assign status_o = status_q;

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !status_q) |=> !status_q);

  assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && status_q && !clr_i) |=> status_q);

  assert_level_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_HIGH && en && cur) |=> status_q);

  assert_no_stale_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && !armed && !status_q) |=> !status_q);

endmodule

// File: rtl/gpio_irq_selector.sv
module gpio_irq_selector
  import gis_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int SRC_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [(1<<SRC_W)-1:0] gpio_irq_in,
  output logic [NUM_CH-1:0]     irq_out
);

  localparam int NUM_SRC = 1 << SRC_W;

  logic [NUM_SRC-1:0]       src_sync;
  logic [NUM_CH-1:0][7:0]   sel;
  logic [NUM_CH-1:0][1:0]   sense;
  logic [NUM_CH-1:0]        clr;
  logic [NUM_CH-1:0]        status;

  gis_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (gpio_irq_in),
    .sync_o  (src_sync)
  );

  gis_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .status_i  (status),
    .sel_o     (sel),
    .sense_o   (sense),
    .clr_o     (clr)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      gis_channel #(.SRC_W(SRC_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_bus  (src_sync),
        .sel_i    (sel[ch]),
        .sense_i  (sense[ch]),
        .clr_i    (clr[ch]),
        .status_o (status[ch])
      );
    end
  endgenerate

  assign irq_out = status;

  // R10: requests to the parent are the status bits, seen through a read.
  assert_req_matches_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[ADDR_W-1:2] == STAT_WORD[ADDR_W-3:0])
      |=> (reg_rdata[NUM_CH-1:0] == $past(irq_out)));

endmodule

// File: tb/tb_gpio_irq_selector.sv
`timescale 1ns/1ps
module tb_gpio_irq_selector;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] gpio = '0;
  logic [31:0]  irq_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_selector dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gpio_irq_in(gpio), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_out after reset", irq_out, 32'h0);
    rd(8'h20, d); check("R1 status reset", d, 32'h0);
    rd(8'h24, d); check("R1 sense lo reset", d, 32'h0);
    rd(8'h28, d); check("R1 sense hi reset", d, 32'h0);
    rd(8'h3C, d); check("R1 select reset", d, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(8'h34, 32'h0403_0201);
    wr(8'h28, 32'hA5A5_5A5A);
    rd(8'h34, d); check("R2 select readback", d, 32'h0403_0201);
    rd(8'h28, d); check("R2 sense readback", d, 32'hA5A5_5A5A);
    rd(8'h2C, d); check("R2 unmapped 0x2C", d, 32'h0);
    rd(8'h00, d); check("R2 unmapped 0x00", d, 32'h0);
    check("R4 disabled channels stay low", irq_out, 32'h0);
    wr(8'h34, 32'h0); wr(8'h28, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    // channel 5: byte 1 of 0x34, enabled, source 77, rising
    wr(8'h34, 32'h0000_CD00);
    settle();
    gpio[76] = 1'b1; settle();
    check("R3 other line ignored", irq_out, 32'h0);
    @(negedge clk); gpio[77] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 not before third edge", irq_out, 32'h0);
    @(negedge clk);
    check("R11 R5 rise seen at third edge", irq_out, 32'h0000_0020);
    gpio[77] = 1'b0; settle();
    check("R8 edge status latched", irq_out, 32'h0000_0020);
    rd(8'h20, d); check("R10 status matches request", d, 32'h0000_0020);
    wr(8'h20, 32'hFFFF_FFFF);
    check("R8 write one keeps bit", irq_out, 32'h0000_0020);
    wr(8'h20, 32'hFFFF_FFDF);
    check("R8 write zero clears", irq_out, 32'h0);
    gpio[76] = 1'b0;
    wr(8'h34, 32'h0);
  endtask

  task automatic t_fall();
    // channel 20: sense 0x28 bits 9:8 = 1; select 0x44 byte 0, source 3
    gpio[3] = 1'b1;
    wr(8'h28, 32'h0000_0100);
    wr(8'h44, 32'h0000_0083);
    settle();
    check("R6 no set while high", irq_out, 32'h0);
    gpio[3] = 1'b0; settle();
    check("R6 falling edge sets", irq_out, 32'h0010_0000);
    wr(8'h20, 32'h0);
    wr(8'h44, 32'h0);
    check("R8 cleared after disable", irq_out, 32'h0);
  endtask

  task automatic t_level();
    // channel 31: sense 0x28 bits 31:30; select 0x4C byte 3, source 100
    wr(8'h28, 32'h8000_0000);
    wr(8'h4C, 32'hE400_0000);
    settle();
    check("R7 high level idle", irq_out, 32'h0);
    gpio[100] = 1'b1; settle();
    check("R7 high level follows 1", irq_out, 32'h8000_0000);
    gpio[100] = 1'b0; settle();
    check("R7 high level follows 0", irq_out, 32'h0);
    wr(8'h28, 32'hC000_0000); settle();
    check("R7 low level active", irq_out, 32'h8000_0000);
    wr(8'h20, 32'h0); settle();
    check("R7 level ignores clear", irq_out, 32'h8000_0000);
    wr(8'h4C, 32'h0); settle();
    check("R4 zero byte disables level", irq_out, 32'h0);
    wr(8'h28, 32'h0);
  endtask

  task automatic t_disabled_and_rearm();
    // channel 0: byte 0 of 0x30, source 10, not enabled
    wr(8'h30, 32'h0000_000A);
    gpio[10] = 1'b1; settle();
    check("R4 disabled rise ignored", irq_out, 32'h0);
    wr(8'h24, 32'h0000_0002); settle();
    check("R4 disabled high level ignored", irq_out, 32'h0);
    wr(8'h24, 32'h0);
    wr(8'h30, 32'h0000_008A); settle();
    check("R9 enable on high line no edge", irq_out, 32'h0);
    gpio[11] = 1'b1; settle();
    wr(8'h30, 32'h0000_008B); settle();
    check("R9 reindex to high line no edge", irq_out, 32'h0);
    gpio[11] = 1'b0; settle();
  endtask

  task automatic t_set_wins();
    // channel 0 rising on source 11, line low; rise then clear on set edge
    @(negedge clk); gpio[11] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h0;
    @(negedge clk); reg_wr = 1'b0;
    check("R8 set wins over clear", irq_out, 32'h0000_0001);
    wr(8'h20, 32'h0);
    check("R8 later clear works", irq_out, 32'h0);
    wr(8'h30, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_rise();
    t_fall();
    t_level();
    t_disabled_and_rearm();
    t_set_wins();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

endmodule